// File: doc/BRIEF.md
# Local Interrupt Controller Register Bank

This block is the software-visible register file of a local interrupt controller. A processor reaches it through one 32-bit port addressed by byte offset: a write strobe, a read strobe, the offset and the write data. Registers sit on 16-byte boundaries, so the low four offset bits do not take part in the decode. Each register applies its own write rule as it stores a value. Some registers keep only a byte. One forces its low bits to one. The local vector entries protect two status bits from writes. The error status register clears only when it is written twice in a row without a read between the writes.

The register bank holds the identifier, a read-only version word, the task priority, the logical destination, the destination format, the spurious vector, the error status, six local vector entries and the timer divide setting. Read data is returned one cycle after the read strobe. An access to an offset that matches no register raises a one-cycle decode-error pulse. A hardware input sets error status bits, and a software-enable output follows bit 8 of the spurious vector register.

Top module: `ic_reg_bank`

## Requirements
- R1: After reset every register reads zero, except the destination format register (0xE0), which reads 0xFFFFFFFF, and the version register (0x30), which reads the VERSION parameter (default 0x00050014). sw_enable is 0 and addr_err is 0.
- R2: Registers decode on offset bits 11:4, and bits 3:0 are ignored. The map is: identifier 0x20, version 0x30, task priority 0x80, logical destination 0xD0, destination format 0xE0, spurious vector 0xF0, error status 0x280, local vector entries 0x320, 0x330, 0x340, 0x350, 0x360 and 0x370, divide setting 0x3E0.
- R3: An access (read or write) to any other offset sets addr_err to 1 in the cycle after the strobe, for that cycle only. A read of such an offset returns 0, and a write to it changes no register.
- R4: Writes to the identifier and task priority registers keep wdata[7:0]. Bits 31:8 read 0.
- R5: A write to the version register has no effect on it.
- R6: The logical destination register keeps wdata[31:24]. Bits 23:0 read 0.
- R7: The destination format register keeps wdata[31:28]. Bits 27:0 always read 1.
- R8: In each local vector entry, bits 12 and 14 keep their old value on a write (0 after reset). All other bits take the written value.
- R9: Each cycle, the bits of err_in are ORed into the error status register (bits 7:0; the upper bits read 0). The first write arms an internal flag and leaves the value unchanged. A write while the flag is armed loads err_in (0 when idle) and disarms the flag. A read of the register disarms the flag.
- R10: The spurious vector register stores all 32 written bits. Every write to it copies wdata[8] to sw_enable in the next cycle.
- R11: The divide setting register keeps wdata bits 3, 1 and 0. All other bits read 0.
- R12: rdata changes only in the cycle after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| err_in | input | 8 | Error events, ORed into error status each cycle |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| addr_err | output | 1 | One-cycle pulse after an access to a reserved offset |
| sw_enable | output | 1 | Software-enable state taken from spurious vector bit 8 |

## Verification
The bench first checks every register after reset. Then a long run of random reads and writes goes to random mapped offsets with random low nibbles, and some reserved offsets are mixed in. The low nibbles test that the decode ignores bits 3:0. The all-ones and random write data separate each register's mask, forced-one and read-only rules from plain storage, and the reserved offsets show whether a stray access leaks into a real register. Directed sequences on the error status register separate the three cases: write then write, write then read then write, and hardware-set bits.

// File: rtl/icrb_pkg.sv
// Shared types for the interrupt controller register bank.
// Assumes: 32-bit data path; register offsets are 16-byte aligned.
package icrb_pkg;

    localparam int DATA_W = 32;

    // Register selected by an offset decode
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_VERSION,
        SEL_TASKPRI,
        SEL_LDEST,
        SEL_DFMT,
        SEL_SPUR,
        SEL_ERR,
        SEL_LVT,
        SEL_DIV
    } reg_sel_e;

    // Read-only status bits inside a local vector entry
    localparam logic [DATA_W-1:0] LVT_RO_MASK = 32'h0000_5000;

endpackage

// File: rtl/ic_offset_decode.sv
// Offset decoder: maps a byte offset to a register select.
// Assumes: only offset bits above bit 3 take part; purely combinational.
module ic_offset_decode
    import icrb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LVT_N  = 6
) (
    input  logic [ADDR_W-1:0]         addr,
    output reg_sel_e                  sel,
    output logic [$clog2(LVT_N)-1:0]  lvt_idx,
    output logic                      hit
);
    localparam int IDX_W   = ADDR_W - 4;
    localparam int LVT_IW  = $clog2(LVT_N);
    localparam int LVT_BASE = 'h32;

    logic [IDX_W-1:0] idx;
    logic [3:0]       unused_low_nibble;
    logic [8:0]       match;
    logic [IDX_W-1:0] lvt_off;

    assign idx               = addr[ADDR_W-1:4];
    assign unused_low_nibble = addr[3:0];
    assign lvt_off           = idx - IDX_W'(LVT_BASE);

    // Compare the slot index against every mapped register
    always_comb begin
        match[0] = (idx == IDX_W'('h02));
        match[1] = (idx == IDX_W'('h03));
        match[2] = (idx == IDX_W'('h08));
        match[3] = (idx == IDX_W'('h0D));
        match[4] = (idx == IDX_W'('h0E));
        match[5] = (idx == IDX_W'('h0F));
        match[6] = (idx == IDX_W'('h28));
        match[7] = (idx >= IDX_W'(LVT_BASE)) && (idx < IDX_W'(LVT_BASE + LVT_N));
        match[8] = (idx == IDX_W'('h3E));
    end

    // Turn the match vector into a register select
    always_comb begin
        sel = SEL_NONE;
        if (match[0]) sel = SEL_IDENT;
        if (match[1]) sel = SEL_VERSION;
        if (match[2]) sel = SEL_TASKPRI;
        if (match[3]) sel = SEL_LDEST;
        if (match[4]) sel = SEL_DFMT;
        if (match[5]) sel = SEL_SPUR;
        if (match[6]) sel = SEL_ERR;
        if (match[7]) sel = SEL_LVT;
        if (match[8]) sel = SEL_DIV;
    end

    assign hit     = |match;
    assign lvt_idx = lvt_off[LVT_IW-1:0];

    // At most one register claims an offset (R2)
    always_comb begin
        assert_decode_onehot_R2: assert ($onehot0(match));
    end

endmodule

// File: rtl/ic_err_status.sv
// Error status register with the write-twice clear handshake.
// Assumes: wr and rd are already qualified by the decode for this register.
module ic_err_status #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [ERR_W-1:0] err_in,
    output logic [ERR_W-1:0] value
);
    logic armed;

    // Collect error events and run the arm/clear handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            armed <= 1'b0;
        end else if (wr) begin
            if (armed) begin
                value <= err_in;
                armed <= 1'b0;
            end else begin
                value <= value | err_in;
                armed <= 1'b1;
            end
        end else begin
            value <= value | err_in;
            if (rd) armed <= 1'b0;
        end
    end

    // A write while armed clears all but the new events (R9)
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && armed) |=> (value == $past(err_in)));

    // A write while unarmed arms and keeps the value (R9)
    assert_err_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !armed) |=> (armed && value == ($past(value) | $past(err_in))));

    // A read alone disarms (R9)
    assert_err_read_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !armed);

endmodule

// File: rtl/ic_lvt_bank.sv
// Bank of local vector entries, each protecting two status bits from writes.
// Assumes: one access port; wr is qualified by the decode.
module ic_lvt_bank
    import icrb_pkg::*;
#(
    parameter int LVT_N = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [$clog2(LVT_N)-1:0]  idx,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rd_val
);
    localparam int LVT_IW = $clog2(LVT_N);

    logic [DATA_W-1:0] entry [LVT_N];

    for (genvar g = 0; g < LVT_N; g++) begin : g_entry
        logic sel_here;
        assign sel_here = wr && (idx == LVT_IW'(g));

        // Store writable bits, keep the status bits
        always_ff @(posedge clk) begin
            if (!rst_n) entry[g] <= '0;
            else if (sel_here) entry[g] <= (wdata & ~LVT_RO_MASK) | (entry[g] & LVT_RO_MASK);
        end

        // Status bits survive writes (R8)
        assert_lvt_status_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sel_here |=> ((entry[g] & LVT_RO_MASK) == ($past(entry[g]) & LVT_RO_MASK)));
    end

    // Select the addressed entry for reading
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < LVT_N; i++)
            if (idx == LVT_IW'(i)) rd_val = entry[i];
    end

endmodule

// File: rtl/ic_reg_bank.sv
// Register bank of a local interrupt controller.
// Decodes byte offsets, applies each register's write rule and returns read
// data one cycle after a read strobe. Assumes at most one offset per cycle.
module ic_reg_bank
    import icrb_pkg::*;
#(
    parameter int           ADDR_W  = 12,
    parameter int           LVT_N   = 6,
    parameter int           ERR_W   = 8,
    parameter logic [31:0]  VERSION = 32'h0005_0014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [ERR_W-1:0]  err_in,
    output logic [31:0]       rdata,
    output logic              addr_err,
    output logic              sw_enable
);
    localparam int LVT_IW = $clog2(LVT_N);

    reg_sel_e            sel;
    logic [LVT_IW-1:0]   lvt_idx;
    logic                hit;
    logic [7:0]          ident_q, taskpri_q, ldest_q;
    logic [3:0]          dfmt_q;
    logic [DATA_W-1:0]   spur_q;
    logic [2:0]          div_q;
    logic [ERR_W-1:0]    err_val;
    logic [DATA_W-1:0]   lvt_val;
    logic [DATA_W-1:0]   rd_mux;
    logic                wr_lvt, wr_err, rd_err;

    ic_offset_decode #(.ADDR_W(ADDR_W), .LVT_N(LVT_N)) u_decode (
        .addr    (addr),
        .sel     (sel),
        .lvt_idx (lvt_idx),
        .hit     (hit)
    );

    assign wr_lvt = wr_en && (sel == SEL_LVT);
    assign wr_err = wr_en && (sel == SEL_ERR);
    assign rd_err = rd_en && (sel == SEL_ERR);

    ic_lvt_bank #(.LVT_N(LVT_N)) u_lvt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_lvt),
        .idx    (lvt_idx),
        .wdata  (wdata),
        .rd_val (lvt_val)
    );

    ic_err_status #(.ERR_W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_err),
        .rd     (rd_err),
        .err_in (err_in),
        .value  (err_val)
    );

    // Plain registers with their write masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident_q   <= '0;
            taskpri_q <= '0;
            ldest_q   <= '0;
            dfmt_q    <= '1;
            spur_q    <= '0;
            div_q     <= '0;
            sw_enable <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_IDENT:   ident_q   <= wdata[7:0];
                SEL_TASKPRI: taskpri_q <= wdata[7:0];
                SEL_LDEST:   ldest_q   <= wdata[31:24];
                SEL_DFMT:    dfmt_q    <= wdata[31:28];
                SEL_SPUR: begin
                    spur_q    <= wdata;
                    sw_enable <= wdata[8];
                end
                SEL_DIV:     div_q     <= {wdata[3], wdata[1:0]};
                default: ;
            endcase
        end
    end

    // Assemble the read value of the selected register
    always_comb begin
        case (sel)
            SEL_IDENT:   rd_mux = {24'h0, ident_q};
            SEL_VERSION: rd_mux = VERSION;
            SEL_TASKPRI: rd_mux = {24'h0, taskpri_q};
            SEL_LDEST:   rd_mux = {ldest_q, 24'h0};
            SEL_DFMT:    rd_mux = {dfmt_q, 28'hFFF_FFFF};
            SEL_SPUR:    rd_mux = spur_q;
            SEL_ERR:     rd_mux = {{(DATA_W-ERR_W){1'b0}}, err_val};
            SEL_LVT:     rd_mux = lvt_val;
            SEL_DIV:     rd_mux = {28'h0, div_q[2], 1'b0, div_q[1:0]};
            default:     rd_mux = '0;
        endcase
    end

    // Register read data and the decode-error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            addr_err <= 1'b0;
        end else begin
            if (rd_en) rdata <= rd_mux;
            addr_err <= (wr_en || rd_en) && !hit;
        end
    end

    // Reserved access raises the error pulse (R3)
    assert_addr_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !hit) |=> addr_err);

    // Read data holds without a read strobe (R12)
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // Spurious vector bit 8 reaches the enable output (R10)
    assert_sw_enable_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SPUR) |=> (sw_enable == $past(wdata[8])));

    // Identifier keeps the low byte of a write (R4)
    assert_ident_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IDENT) |=> (ident_q == $past(wdata[7:0])));

    // Version reads back the fixed value (R5)
    assert_version_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_VERSION) |=> (rdata == VERSION));

    // Destination format reads its low bits as ones (R7)
    assert_dfmt_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_DFMT) |=> (rdata[27:0] == 28'hFFF_FFFF));

endmodule

// File: tb/test_ic_reg_bank.sv
module test_ic_reg_bank;
    localparam logic [31:0] VER = 32'h0005_0014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  err_in = '0;
    logic [31:0] rdata;
    logic        addr_err, sw_enable;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] mdl [14];
    bit m_armed;
    bit m_sw;

    always #4 clk = ~clk;

    ic_reg_bank i_ic_reg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .err_in(err_in), .rdata(rdata), .addr_err(addr_err),
        .sw_enable(sw_enable)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] base_of(int s);
        case (s)
            0: return 12'h020;  1: return 12'h030;  2: return 12'h080;
            3: return 12'h0D0;  4: return 12'h0E0;  5: return 12'h0F0;
            6: return 12'h280;  13: return 12'h3E0;
            default: return 12'h320 + 12'(16 * (s - 7));
        endcase
    endfunction

    function automatic int slot_of(logic [11:0] a);
        for (int s = 0; s < 14; s++)
            if (base_of(s) == {a[11:4], 4'h0}) return s;
        return -1;
    endfunction

    function automatic string req_of(int s);
        case (s)
            0, 2: return "R4";  1: return "R5";  3: return "R6";  4: return "R7";
            5: return "R10"; 6: return "R9"; 13: return "R11";
            -1: return "R3";
            default: return "R8";
        endcase
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 14; s++) mdl[s] = '0;
        mdl[1] = VER;
        mdl[4] = 32'hFFFF_FFFF;
        m_armed = 0;
        m_sw = 0;
    endtask

    task automatic model_write(int s, logic [31:0] d);
        case (s)
            0, 2: mdl[s] = {24'h0, d[7:0]};
            1: ;
            3: mdl[s] = {d[31:24], 24'h0};
            4: mdl[s] = d | 32'h0FFF_FFFF;
            5: begin mdl[s] = d; m_sw = d[8]; end
            6: begin
                if (m_armed) begin mdl[s] = '0; m_armed = 0; end
                else m_armed = 1;
            end
            13: mdl[s] = d & 32'h0000_000B;
            -1: ;
            default: mdl[s] = (d & ~32'h5000) | (mdl[s] & 32'h5000);
        endcase
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        int s = slot_of(a);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(s, d);
        check(addr_err == (s < 0), "R3 write addr_err", {31'h0, addr_err}, {31'h0, s < 0});
        if (s == 5) check(sw_enable == m_sw, "R10 sw_enable", {31'h0, sw_enable}, {31'h0, m_sw});
    endtask

    task automatic do_read(logic [11:0] a);
        int s = slot_of(a);
        logic [31:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        e = (s < 0) ? 32'h0 : mdl[s];
        if (s == 6) m_armed = 0;
        check(rdata == e, req_of(s), rdata, e);
        check(addr_err == (s < 0), "R3 read addr_err", {31'h0, addr_err}, {31'h0, s < 0});
    endtask

    initial begin
        void'($urandom(1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and every register
        check(sw_enable == 1'b0, "R1 sw_enable", {31'h0, sw_enable}, 32'h0);
        check(addr_err == 1'b0, "R1 addr_err", {31'h0, addr_err}, 32'h0);
        for (int s = 0; s < 14; s++) begin
            do_read(base_of(s));
            check(rdata == mdl[s], "R1 reset value", rdata, mdl[s]);
        end

        // R2: low nibble ignored
        do_write(12'h02F, 32'hA5A5_A5C3);
        do_read(12'h027);
        check(rdata == 32'h0000_00C3, "R2 low nibble", rdata, 32'h0000_00C3);

        // R3: reserved read, pulse lasts one cycle, write changes nothing
        do_read(12'h040);
        @(negedge clk);
        check(addr_err == 1'b0, "R3 pulse width", {31'h0, addr_err}, 32'h0);
        do_write(12'h3F0, 32'hFFFF_FFFF);
        do_read(12'h3E0);

        // R12: read data held while no read
        do_read(12'h030);
        repeat (3) @(negedge clk);
        check(rdata == VER, "R12 hold", rdata, VER);

        // R5, R6, R7, R8, R11 with all ones
        for (int s = 0; s < 14; s++) begin
            do_write(base_of(s), 32'hFFFF_FFFF);
            do_read(base_of(s));
        end

        // R10: sw_enable follows bit 8 both ways
        do_write(12'h0F0, 32'h0000_0100);
        do_write(12'h0F0, 32'h1234_5EFF);

        // R9: hardware set, arm then clear
        @(negedge clk); err_in = 8'h5A;
        @(negedge clk); err_in = 8'h00;
        mdl[6] = 32'h5A;
        do_read(12'h280);
        do_write(12'h280, 32'h0);
        do_read(12'h280);
        check(rdata == 32'h5A, "R9 arm keeps value", rdata, 32'h5A);
        do_write(12'h280, 32'h0);
        do_write(12'h280, 32'h0);
        do_read(12'h280);
        check(rdata == 32'h0, "R9 second write clears", rdata, 32'h0);
        // R9: read between writes disarms
        @(negedge clk); err_in = 8'h81;
        @(negedge clk); err_in = 8'h00;
        mdl[6] = 32'h81;
        do_write(12'h280, 32'h0);
        do_read(12'h280);
        do_write(12'h280, 32'h0);
        do_read(12'h280);
        check(rdata == 32'h81, "R9 read disarms", rdata, 32'h81);

        // Random mix across all registers and reserved offsets
        for (int n = 0; n < 600; n++) begin
            int s = $urandom_range(0, 14);
            logic [11:0] a;
            logic [31:0] d = $urandom();
            if (s == 14) begin
                case ($urandom_range(0, 3))
                    0: a = 12'h000; 1: a = 12'h100; 2: a = 12'h380; default: a = 12'h3F0;
                endcase
            end else a = base_of(s);
            a[3:0] = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule